// File: doc/BRIEF.md
# Byte-level SMBus slave engine with status reporting

This block lets a chip answer as a slave on a two-wire SMBus / I2C bus. It samples the clock and data lines through two-flop synchronisers and finds START, repeated START and STOP conditions. It also finds the rising and falling edges of the clock. It shifts in the first byte after a START and compares the upper seven bits with a programmed address. On a match it acknowledges in hardware. It then either receives bytes, acknowledging each one as the host has chosen, or transmits bytes that the host supplies.

After each byte-level event the block raises an interrupt flag and presents a 4-bit status code with an ACK flag and an error flag. For byte events it also holds the clock line low until the host clears the flag. The host side is a small register port. It has a transmit-byte load strobe, an acknowledge-choice write strobe, a flag-clear strobe, and read-only status, flags and received byte. Both bus lines are open-drain: the block only outputs drive-low enables.

Top module: `smbs_slave`

## Requirements
- R1: After reset the interrupt flag is 0 and neither bus line is driven low.
- R2: When the first byte after a START carries the programmed address in bits 7..1, the block drives ACK during the ninth clock. At the end of that clock it raises the flag with status 0010 and ACK flag 1. Bit 0 of that byte selects read (1) or write (0).
- R3: When the address does not match, the block sends no ACK and raises no flag. It ignores all bytes until the next START.
- R4: Each byte received in write mode is reported as status 0000, with the byte on rx_byte. The block acknowledges that byte with the acknowledge choice held when its eighth bit ended (1 = ACK). The ACK flag shows what was actually sent.
- R5: In read mode the block sends the host's byte MSB first. A byte loaded in the same cycle as the flag clear is the one sent. After the master's ACK bit the block reports status 0100, with the ACK flag set to 1 for ACK and 0 for NACK.
- R6: After the master NACKs a transmitted byte, the block drives no data. A following STOP is reported as status 0001.
- R7: A STOP while addressed, outside a transmission, is reported as status 0001. The clock is not stretched.
- R8: A STOP while a transmitted byte or its ACK bit is in progress is reported as status 0101, with the error flag at 1.
- R9: When a transmitted 1 is read back as 0 on the bus, the block releases SDA for the rest of the byte. It reports status 0100 with the error flag at 1 and then waits for the master to end the transfer.
- R10: During byte reports (0000, 0010, 0100) SCL is held low while the flag is set. SCL is released two cycles after the cycle in which the flag is cleared. The SDA drive changes only while SCL is low.
- R11: A repeated START while addressed returns the block to address reception without reporting 0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | DATA_W-1 | Programmed 7-bit slave address |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| host_tx_load | input | 1 | Strobe: capture host_tx_byte as the next byte to send |
| host_tx_byte | input | DATA_W | Byte to transmit |
| host_ack_wr | input | 1 | Strobe: update the acknowledge choice |
| host_ack_val | input | 1 | New acknowledge choice (1 = ACK) |
| host_clear | input | 1 | Strobe: clear the interrupt flag |
| irq | output | 1 | Interrupt flag |
| status | output | 4 | Code of the last reported event |
| ack_flag | output | 1 | ACK sent or received for the reported event |
| err_flag | output | 1 | Fault seen for the reported event |
| rx_byte | output | DATA_W | Last received data byte |

## Verification
The host's response strobes and the bus event they answer meet in the same cycle. The bench's scoreboard monitor sends the transmit-byte load, or the acknowledge-choice write, in the very cycle it clears the flag. The master model then reads the transmitted byte back, or sees the ACK/NACK that results. In the read transfer the register still holds the previous byte, so only a same-cycle load that takes effect produces the expected second byte. The repeated-START and illegal-STOP cases are judged by the order of popped status codes, since no 0001 may slip in between.

// File: rtl/smbs_pkg.sv
package smbs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_AACK_DRV,
        S_AACK_HOLD,
        S_RX,
        S_RACK_DRV,
        S_RACK_HOLD,
        S_TX,
        S_TACK_WAIT,
        S_TACK_END,
        S_WAIT_STOP
    } state_e;

    localparam logic [3:0] STAT_RX_BYTE = 4'b0000;
    localparam logic [3:0] STAT_STOP    = 4'b0001;
    localparam logic [3:0] STAT_ADDR    = 4'b0010;
    localparam logic [3:0] STAT_TX_BYTE = 4'b0100;
    localparam logic [3:0] STAT_BUS_ERR = 4'b0101;

endpackage

// File: rtl/smbs_sync.sv
module smbs_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [STAGES-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '1;
            else        pipe_q <= pipe_d;
        end

        assign dout[i] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/smbs_cond.sv
module smbs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign start_det = scl_s & prev_q.scl & prev_q.sda & ~sda_s;
    assign stop_det  = scl_s & prev_q.scl & ~prev_q.sda & sda_s;
    assign scl_rise  = scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s & prev_q.scl;

endmodule

// File: rtl/smbs_fsm.sv
module smbs_fsm
    import smbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              host_tx_load,
    input  logic [DATA_W-1:0] host_tx_byte,
    input  logic              host_ack_wr,
    input  logic              host_ack_val,
    input  logic              host_clear,
    output logic              scl_low,
    output logic              sda_low,
    output logic              irq,
    output logic [3:0]        status,
    output logic              ack_flag,
    output logic              err_flag,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(DATA_W);

    typedef struct packed {
        state_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] txr;
        logic              rw;
        logic              ackb;
        logic              errp;
        logic              irq;
        logic              stretch;
        logic [3:0]        stat;
        logic              ackf;
        logic              errf;
        logic [DATA_W-1:0] rxb;
        logic              scl_low;
        logic              sda_low;
    } regs_t;

    localparam regs_t RESET_VAL = '{st: S_IDLE, cnt: '0, sh: '0, txr: '0, rw: 1'b0,
                                    ackb: 1'b1, errp: 1'b0, irq: 1'b0, stretch: 1'b0,
                                    stat: STAT_RX_BYTE, ackf: 1'b0, errf: 1'b0,
                                    rxb: '0, scl_low: 1'b0, sda_low: 1'b0};

    regs_t q, d;

    function automatic regs_t post(regs_t r, logic [3:0] code, logic a, logic e, logic hold);
        regs_t o;
        o         = r;
        o.irq     = 1'b1;
        o.stat    = code;
        o.ackf    = a;
        o.errf    = e;
        o.stretch = hold;
        return o;
    endfunction

    always_comb begin
        logic [DATA_W-1:0] in_byte;
        in_byte = {q.sh[DATA_W-2:0], sda_s};
        d = q;
        d.scl_low = q.irq & q.stretch;

        if (host_tx_load) d.txr  = host_tx_byte;
        if (host_ack_wr)  d.ackb = host_ack_val;

        if (host_clear && q.irq) begin
            d.irq     = 1'b0;
            d.stretch = 1'b0;
            if (q.st == S_TX) begin
                d.sh      = host_tx_load ? host_tx_byte : q.txr;
                d.sda_low = ~d.sh[DATA_W-1];
                d.cnt     = '0;
            end
        end

        if (start_det) begin
            d.st      = S_ADDR;
            d.cnt     = '0;
            d.sda_low = 1'b0;
            d.errp    = 1'b0;
        end else if (stop_det) begin
            case (q.st)
                S_IDLE, S_ADDR: ;
                S_TX, S_TACK_WAIT, S_TACK_END: d = post(d, STAT_BUS_ERR, 1'b0, 1'b1, 1'b0);
                default: d = post(d, STAT_STOP, 1'b0, 1'b0, 1'b0);
            endcase
            d.st      = S_IDLE;
            d.sda_low = 1'b0;
            d.errp    = 1'b0;
        end else begin
            case (q.st)
                S_ADDR: if (scl_rise) begin
                    d.sh  = in_byte;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        if (in_byte[DATA_W-1:1] == own_addr) begin
                            d.st = S_AACK_DRV;
                            d.rw = in_byte[0];
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                S_AACK_DRV: if (scl_fall) begin
                    d.sda_low = 1'b1;
                    d.st      = S_AACK_HOLD;
                end
                S_AACK_HOLD: if (scl_fall) begin
                    d.sda_low = 1'b0;
                    d         = post(d, STAT_ADDR, 1'b1, 1'b0, 1'b1);
                    d.cnt     = '0;
                    d.st      = q.rw ? S_TX : S_RX;
                end
                S_RX: if (scl_rise) begin
                    d.sh  = in_byte;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        d.rxb = in_byte;
                        d.st  = S_RACK_DRV;
                    end
                end
                S_RACK_DRV: if (scl_fall) begin
                    d.sda_low = q.ackb;
                    d.st      = S_RACK_HOLD;
                end
                S_RACK_HOLD: if (scl_fall) begin
                    d.sda_low = 1'b0;
                    d         = post(d, STAT_RX_BYTE, q.sda_low, 1'b0, 1'b1);
                    d.cnt     = '0;
                    d.st      = S_RX;
                end
                S_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                        if (!q.sda_low && !sda_s) d.errp = 1'b1;
                    end else if (scl_fall && q.cnt != '0) begin
                        if (q.cnt == ALL_BITS) begin
                            d.sda_low = 1'b0;
                            d.st      = S_TACK_WAIT;
                        end else begin
                            d.sh      = q.sh << 1;
                            d.sda_low = ~d.sh[DATA_W-1] & ~q.errp;
                        end
                    end
                end
                S_TACK_WAIT: if (scl_rise) begin
                    d.sh[0] = ~sda_s;
                    d.st    = S_TACK_END;
                end
                S_TACK_END: if (scl_fall) begin
                    d      = post(d, STAT_TX_BYTE, q.sh[0], q.errp, 1'b1);
                    d.cnt  = '0;
                    d.errp = 1'b0;
                    d.st   = (q.sh[0] && !q.errp) ? S_TX : S_WAIT_STOP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RESET_VAL;
        else        q <= d;
    end

    assign scl_low  = q.scl_low;
    assign sda_low  = q.sda_low;
    assign irq      = q.irq;
    assign status   = q.stat;
    assign ack_flag = q.ackf;
    assign err_flag = q.errf;
    assign rx_byte  = q.rxb;

endmodule

// File: rtl/smbs_slave.sv
module smbs_slave #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-2:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              host_tx_load,
    input  logic [DATA_W-1:0] host_tx_byte,
    input  logic              host_ack_wr,
    input  logic              host_ack_val,
    input  logic              host_clear,
    output logic              irq,
    output logic [3:0]        status,
    output logic              ack_flag,
    output logic              err_flag,
    output logic [DATA_W-1:0] rx_byte
);

    logic [1:0] lines_s;
    logic       start_det, stop_det, scl_rise, scl_fall;

    smbs_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_in, sda_in}),
        .dout (lines_s)
    );

    smbs_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .start_det(start_det),
        .stop_det (stop_det),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    smbs_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .own_addr    (own_addr),
        .sda_s       (lines_s[0]),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .host_tx_load(host_tx_load),
        .host_tx_byte(host_tx_byte),
        .host_ack_wr (host_ack_wr),
        .host_ack_val(host_ack_val),
        .host_clear  (host_clear),
        .scl_low     (scl_drive_low),
        .sda_low     (sda_drive_low),
        .irq         (irq),
        .status      (status),
        .ack_flag    (ack_flag),
        .err_flag    (err_flag),
        .rx_byte     (rx_byte)
    );

endmodule

// File: rtl/smbs_slave_chk.sv
module smbs_slave_chk
    import smbs_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_in,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic       host_clear,
    input logic       irq,
    input logic [3:0] status,
    input logic       ack_flag,
    input logic       err_flag
);

    // R10: SDA drive only changes while the clock line is low
    a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_in);

    // R10: stretching only happens with a flag pending (or just cleared)
    a_r10_stretch_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> (irq || $past(irq)));

    // R10: clearing the flag releases SCL two cycles later
    a_r10_release_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_clear && irq) |=> ##1 !scl_drive_low);

    // R2: an address report always carries ACK and no error
    a_r2_addr_acked: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && status == STAT_ADDR) |-> (ack_flag && !err_flag));

    // R8: bus-error report carries the error flag and does not stretch
    a_r8_buserr_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && status == STAT_BUS_ERR) |-> (err_flag && !scl_drive_low));

    // R7: STOP report never stretches the clock
    a_r7_stop_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && status == STAT_STOP) |=> !scl_drive_low);

endmodule

bind smbs_slave smbs_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_in       (scl_in),
    .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low),
    .host_clear   (host_clear),
    .irq          (irq),
    .status       (status),
    .ack_flag     (ack_flag),
    .err_flag     (err_flag)
);

// File: tb/test_smbs_slave.sv
module test_smbs_slave;

    localparam int T = 10;
    localparam logic [6:0] ADDR = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_drive_low, sda_drive_low;
    logic scl_line, sda_line;
    logic h_load = 0, h_aw = 0, h_av = 0, h_clear = 0;
    logic [7:0] h_byte = '0;
    logic irq, ack_flag, err_flag;
    logic [3:0] status;
    logic [7:0] rx_byte;

    assign scl_line = m_scl & ~scl_drive_low;
    assign sda_line = m_sda & ~sda_drive_low;

    smbs_slave i_smbs_slave (
        .clk(clk), .rst_n(rst_n), .own_addr(ADDR),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .host_tx_load(h_load), .host_tx_byte(h_byte),
        .host_ack_wr(h_aw), .host_ack_val(h_av), .host_clear(h_clear),
        .irq(irq), .status(status), .ack_flag(ack_flag),
        .err_flag(err_flag), .rx_byte(rx_byte)
    );

    typedef struct {
        logic [3:0] st;
        logic       ack;
        logic       err;
        logic       rx_chk;
        logic [7:0] rx;
        logic       ld;
        logic [7:0] ld_b;
        logic       aw;
        logic       av;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [3:0] st, input logic ack, input logic err,
                        input logic rx_chk, input logic [7:0] rx,
                        input logic ld, input logic [7:0] ld_b,
                        input logic aw, input logic av);
        exp_t e;
        e.st = st; e.ack = ack; e.err = err; e.rx_chk = rx_chk; e.rx = rx;
        e.ld = ld; e.ld_b = ld_b; e.aw = aw; e.av = av;
        exp_q.push_back(e);
    endtask

    // scoreboard monitor: pops expected report, compares, answers as the host
    initial begin
        forever begin
            @(negedge clk);
            if (irq === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected flag, status", 32'(status), 32'hF);
                    h_clear = 1;
                    @(negedge clk);
                    h_clear = 0;
                end else begin
                    exp_t e;
                    bit hold;
                    e = exp_q.pop_front();
                    chk(status === e.st, "R4", "status code", 32'(status), 32'(e.st));
                    chk(ack_flag === e.ack, "R5", "ack flag", 32'(ack_flag), 32'(e.ack));
                    chk(err_flag === e.err, "R9", "err flag", 32'(err_flag), 32'(e.err));
                    if (e.rx_chk)
                        chk(rx_byte === e.rx, "R4", "rx byte", 32'(rx_byte), 32'(e.rx));
                    hold = !(e.st == 4'b0001 || e.st == 4'b0101);
                    @(negedge clk);
                    chk(scl_drive_low === hold, "R10", "stretch while flagged",
                        32'(scl_drive_low), 32'(hold));
                    // host answer lands in the same cycle as the flag clear
                    h_load = e.ld; h_byte = e.ld_b; h_aw = e.aw; h_av = e.av; h_clear = 1;
                    @(negedge clk);
                    h_load = 0; h_aw = 0; h_clear = 0;
                    @(negedge clk);
                    chk(scl_drive_low === 1'b0, "R10", "SCL released after clear",
                        32'(scl_drive_low), 32'h0);
                    chk(irq === 1'b0, "R10", "flag cleared", 32'(irq), 32'h0);
                end
            end
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic raise_scl();
        m_scl = 1;
        @(negedge clk);
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 0; waitc(T); m_scl = 0; waitc(T);
    endtask

    task automatic m_rep_start();
        m_sda = 1; waitc(T); raise_scl(); waitc(T); m_sda = 0; waitc(T); m_scl = 0; waitc(T);
    endtask

    task automatic m_stop();
        m_sda = 0; waitc(T); raise_scl(); waitc(T); m_sda = 1; waitc(T);
    endtask

    task automatic m_wbit(input logic b);
        m_sda = b; waitc(T); raise_scl(); waitc(T); m_scl = 0; waitc(2);
    endtask

    task automatic m_rbit(output logic b);
        m_sda = 1; waitc(T); raise_scl(); waitc(T / 2); b = sda_line; waitc(T / 2);
        m_scl = 0; waitc(2);
    endtask

    task automatic m_wbyte(input logic [7:0] v, output logic acked);
        logic nak;
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(nak);
        acked = !nak;
    endtask

    task automatic m_rbyte(output logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) m_rbit(v[i]);
        m_wbit(!ack);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        waitc(20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] b;
        logic [6:0] tail;
        waitc(5);
        rst_n = 1;
        waitc(5);
        // R1 reset state
        chk(irq === 1'b0, "R1", "irq after reset", 32'(irq), 0);
        chk(scl_drive_low === 1'b0, "R1", "scl drive after reset", 32'(scl_drive_low), 0);
        chk(sda_drive_low === 1'b0, "R1", "sda drive after reset", 32'(sda_drive_low), 0);

        // write transfer: R2, R4, R7
        push(4'b0010, 1, 0, 0, 0, 0, 0, 1, 1);
        m_start();
        m_wbyte({ADDR, 1'b0}, a);
        chk(a === 1'b1, "R2", "address ACK (write)", 32'(a), 1);
        push(4'b0000, 1, 0, 1, 8'hA5, 0, 0, 1, 0);
        m_wbyte(8'hA5, a);
        chk(a === 1'b1, "R4", "data ACK", 32'(a), 1);
        push(4'b0000, 0, 0, 1, 8'h3C, 0, 0, 1, 1);
        m_wbyte(8'h3C, a);
        chk(a === 1'b0, "R4", "data NACK chosen by host", 32'(a), 0);
        push(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0);
        m_stop();
        drain();

        // read transfer: R2, R5, R6
        push(4'b0010, 1, 0, 0, 0, 1, 8'h96, 0, 0);
        m_start();
        m_wbyte({ADDR, 1'b1}, a);
        chk(a === 1'b1, "R2", "address ACK (read)", 32'(a), 1);
        push(4'b0100, 1, 0, 0, 0, 1, 8'h5B, 0, 0);
        m_rbyte(b, 1);
        chk(b === 8'h96, "R5", "first byte read", 32'(b), 32'h96);
        push(4'b0100, 0, 0, 0, 0, 0, 0, 0, 0);
        m_rbyte(b, 0);
        chk(b === 8'h5B, "R5", "same-cycle load byte read", 32'(b), 32'h5B);
        drain();
        chk(sda_drive_low === 1'b0, "R6", "no drive after NACK", 32'(sda_drive_low), 0);
        push(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0);
        m_stop();
        drain();

        // non-matching address: R3
        m_start();
        m_wbyte({ADDR ^ 7'h01, 1'b0}, a);
        chk(a === 1'b0, "R3", "no ACK on mismatch", 32'(a), 0);
        m_wbyte(8'h55, a);
        chk(a === 1'b0, "R3", "data ignored after mismatch", 32'(a), 0);
        m_stop();
        waitc(40);
        chk(irq === 1'b0, "R3", "no flag after mismatch", 32'(irq), 0);

        // repeated START: R11
        push(4'b0010, 1, 0, 0, 0, 0, 0, 0, 0);
        m_start();
        m_wbyte({ADDR, 1'b0}, a);
        push(4'b0000, 1, 0, 1, 8'h11, 0, 0, 0, 0);
        m_wbyte(8'h11, a);
        push(4'b0010, 1, 0, 0, 0, 1, 8'hE7, 0, 0);
        m_rep_start();
        m_wbyte({ADDR, 1'b1}, a);
        chk(a === 1'b1, "R11", "address ACK after repeated START", 32'(a), 1);
        push(4'b0100, 0, 0, 0, 0, 0, 0, 0, 0);
        m_rbyte(b, 0);
        chk(b === 8'hE7, "R11", "byte read after repeated START", 32'(b), 32'hE7);
        push(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0);
        m_stop();
        drain();

        // STOP in the middle of a transmitted byte: R8
        push(4'b0010, 1, 0, 0, 0, 1, 8'hFF, 0, 0);
        m_start();
        m_wbyte({ADDR, 1'b1}, a);
        m_rbit(b[7]); m_rbit(b[6]); m_rbit(b[5]);
        push(4'b0101, 0, 1, 0, 0, 0, 0, 0, 0);
        m_stop();
        drain();

        // bit conflict during transmit: R9
        push(4'b0010, 1, 0, 0, 0, 1, 8'hF0, 0, 0);
        m_start();
        m_wbyte({ADDR, 1'b1}, a);
        push(4'b0100, 0, 1, 0, 0, 0, 0, 0, 0);
        m_wbit(1'b0);
        for (int i = 6; i >= 0; i--) m_rbit(tail[i]);
        m_wbit(1'b1);
        chk(tail === 7'h7F, "R9", "SDA released after conflict", 32'(tail), 32'h7F);
        drain();
        push(4'b0001, 0, 0, 0, 0, 0, 0, 0, 0);
        m_stop();
        drain();

        chk(exp_q.size() == 0, "R7", "all reports seen", 32'(exp_q.size()), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule